// File: doc/BRIEF.md
# Four-bit carry look-ahead group

This block takes the propagate and generate terms of four adjacent positions plus an incoming carry. From these it produces every carry into and out of the group in one flat layer of AND-OR logic. No carry waits on the carry of the position below it. It also reports a group propagate and a group generate. A higher tier can combine these to compute carries across several groups.

The block has no clock, reset or storage. The same module sits at both tiers of a two-level adder. At the lower tier its inputs are per-bit terms formed from operand bits. At the upper tier its inputs are the group terms reported by four lower-tier copies, and its carries become the seed carries of those copies. A per-bit propagate may be formed either as the OR or as the XOR of the two operand bits. The carries come out the same either way.

Top module: `lookahead_group4`

## Requirements
- R1: `carry_mid_o[0]` (carry into position 1) equals gen_i[0] | (prop_i[0] & carry_i).
- R2: `carry_mid_o[1]` (carry into position 2) equals gen_i[1] | prop_i[1]&gen_i[0] | prop_i[1]&prop_i[0]&carry_i.
- R3: `carry_mid_o[2]` (carry into position 3) follows the same pattern, extended through position 2.
- R4: `carry_out_o` equals gen_i[3] | p3g2 | p3p2g1 | p3p2p1g0 | p3p2p1p0&carry_i.
- R5: `grp_prop_o` is the AND of prop_i[3:0], and toggling carry_i leaves it unchanged.
- R6: `grp_gen_o` equals gen_i[3] | p3g2 | p3p2g1 | p3p2p1g0, and toggling carry_i leaves it unchanged.
- R7: `carry_out_o` always equals grp_gen_o | (grp_prop_o & carry_i).
- R8: All outputs are correct for every operand pair when prop_i = a|b and also when prop_i = a^b, with gen_i = a&b.
- R9: Five copies, with four at the lower tier and one at the upper tier fed by the lower copies' group terms, give every carry of a 16-bit addition. The resulting sums a^b^c equal a+b+carry_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prop_i | input | 4 | Propagate term of each position (bit 0 is lowest) |
| gen_i | input | 4 | Generate term of each position |
| carry_i | input | 1 | Carry into position 0 |
| carry_mid_o | output | 3 | Carries into positions 1, 2 and 3 (index 0 is position 1) |
| carry_out_o | output | 1 | Carry out of position 3 |
| grp_prop_o | output | 1 | Group propagate |
| grp_gen_o | output | 1 | Group generate |

## Verification
The assertions compare the flat carries against a position-by-position ripple relation and against the split of the carry-out into group terms. Both relations hold for any combination of propagate and generate bits, so the assertions assume only that the inputs carry known values. The bench goes further. It applies only consistent pairs derived from real operand bits, where generate implies propagate under the OR form and the two are exclusive under the XOR form. It sweeps all 512 operand and carry combinations under each form. A two-tier 16-bit adder built from five copies is checked against integer addition.

// File: rtl/lookahead_pkg.sv
// Package: shared limits for the look-ahead group logic.
// Assumes: a group never spans more than four positions, so every carry
// stays a two-level sum of products of modest fan-in.
package lookahead_pkg;
    localparam int unsigned LA_MAX_SPAN = 4;
    localparam int unsigned LA_DEF_SPAN = 4;
endpackage

// File: rtl/lookahead_carry_sop.sv
// Module: lookahead_carry_sop
// Forms carry k (k = 1..SPAN) as one flat OR of product terms:
//   term j (j < k): gen[j] ANDed with every prop above j and below k
//   term k        : carry_in ANDed with prop[0..k-1]
// Assumes: SPAN <= LA_MAX_SPAN. Purely combinational; no term uses another carry.
module lookahead_carry_sop
    import lookahead_pkg::*;
#(
    parameter int unsigned SPAN = LA_DEF_SPAN
) (
    input  logic [SPAN-1:0] prop_i,
    input  logic [SPAN-1:0] gen_i,
    input  logic            carry_i,
    output logic [SPAN:1]   carry_o
);
    localparam logic [SPAN:0] ONE = {{SPAN{1'b0}}, 1'b1};

    for (genvar k = 1; k <= SPAN; k++) begin : g_carry
        logic [k:0] term;
        // Product term for generate at position j, passed by positions j+1..k-1
        for (genvar j = 0; j < k; j++) begin : g_gen_term
            localparam logic [SPAN:0] HI_FULL = (ONE << k) - ONE;
            localparam logic [SPAN:0] LO_FULL = (ONE << (j + 1)) - ONE;
            localparam logic [SPAN-1:0] MASK  = SPAN'(HI_FULL & ~LO_FULL);
            assign term[j] = gen_i[j] & (&(prop_i | ~MASK));
        end
        // Product term for the incoming carry passed by positions 0..k-1
        localparam logic [SPAN:0]   CIN_FULL = (ONE << k) - ONE;
        localparam logic [SPAN-1:0] CIN_MASK = SPAN'(CIN_FULL);
        assign term[k]    = carry_i & (&(prop_i | ~CIN_MASK));
        // Single OR level over all product terms
        assign carry_o[k] = |term;
    end
endmodule

// File: rtl/lookahead_group_pg.sv
// Module: lookahead_group_pg
// Forms the group propagate (AND of all prop) and the group generate
// (flat OR of generate terms, each passed by every higher position).
// Assumes: SPAN <= LA_MAX_SPAN. Neither output depends on any carry.
module lookahead_group_pg
    import lookahead_pkg::*;
#(
    parameter int unsigned SPAN = LA_DEF_SPAN
) (
    input  logic [SPAN-1:0] prop_i,
    input  logic [SPAN-1:0] gen_i,
    output logic            grp_prop_o,
    output logic            grp_gen_o
);
    localparam logic [SPAN:0] ONE = {{SPAN{1'b0}}, 1'b1};

    logic [SPAN-1:0] gterm;

    // Generate term j passed by positions j+1..SPAN-1
    for (genvar j = 0; j < SPAN; j++) begin : g_term
        localparam logic [SPAN:0]   HI_FULL = (ONE << SPAN) - ONE;
        localparam logic [SPAN:0]   LO_FULL = (ONE << (j + 1)) - ONE;
        localparam logic [SPAN-1:0] MASK    = SPAN'(HI_FULL & ~LO_FULL);
        assign gterm[j] = gen_i[j] & (&(prop_i | ~MASK));
    end

    // Group terms for the next tier
    assign grp_gen_o  = |gterm;
    assign grp_prop_o = &prop_i;
endmodule

// File: rtl/lookahead_group4.sv
// Module: lookahead_group4 (top)
// Four-position carry look-ahead group. Used unchanged at the bit tier
// (inputs from operand bits) and at the group tier (inputs are group
// propagate/generate of lower copies).
// Assumes: inputs are known values; propagate may be OR or XOR of operands.
module lookahead_group4
    import lookahead_pkg::*;
(
    input  logic [3:0] prop_i,
    input  logic [3:0] gen_i,
    input  logic       carry_i,
    output logic [2:0] carry_mid_o,
    output logic       carry_out_o,
    output logic       grp_prop_o,
    output logic       grp_gen_o
);
    localparam int unsigned SPAN = 4;

    logic [SPAN:1] carries;

    // Flat carry logic for positions 1..4
    lookahead_carry_sop #(.SPAN(SPAN)) u_carry (
        .prop_i  (prop_i),
        .gen_i   (gen_i),
        .carry_i (carry_i),
        .carry_o (carries)
    );

    // Group terms for the higher tier
    lookahead_group_pg #(.SPAN(SPAN)) u_grp (
        .prop_i     (prop_i),
        .gen_i      (gen_i),
        .grp_prop_o (grp_prop_o),
        .grp_gen_o  (grp_gen_o)
    );

    assign carry_mid_o = carries[SPAN-1:1];
    assign carry_out_o = carries[SPAN];
endmodule

// File: rtl/lookahead_group4_chk.sv
// Module: lookahead_group4_chk
// Checks the flat carries against a ripple relation, and the carry-out
// against its split into group terms. Holds for any known input values.
module lookahead_group4_chk (
    input logic [3:0] prop_i,
    input logic [3:0] gen_i,
    input logic       carry_i,
    input logic [2:0] carry_mid_o,
    input logic       carry_out_o,
    input logic       grp_prop_o,
    input logic       grp_gen_o
);
    logic known;
    assign known = !$isunknown({prop_i, gen_i, carry_i});

    // Ripple and hierarchy relations between independently built outputs
    always_comb begin
        if (known) begin
            a_r1_ripple_c1: assert (carry_mid_o[0] == (gen_i[0] | (prop_i[0] & carry_i)));
            a_r2_ripple_c2: assert (carry_mid_o[1] == (gen_i[1] | (prop_i[1] & carry_mid_o[0])));
            a_r3_ripple_c3: assert (carry_mid_o[2] == (gen_i[2] | (prop_i[2] & carry_mid_o[1])));
            a_r4_ripple_c4: assert (carry_out_o == (gen_i[3] | (prop_i[3] & carry_mid_o[2])));
            a_r7_split_out: assert (carry_out_o == (grp_gen_o | (grp_prop_o & carry_i)));
            a_r6_gen_forces: assert (!grp_gen_o || carry_out_o);
            a_r5_prop_passes: assert (!(grp_prop_o && carry_i) || carry_out_o);
        end
    end
endmodule

bind lookahead_group4 lookahead_group4_chk u_chk (
    .prop_i      (prop_i),
    .gen_i       (gen_i),
    .carry_i     (carry_i),
    .carry_mid_o (carry_mid_o),
    .carry_out_o (carry_out_o),
    .grp_prop_o  (grp_prop_o),
    .grp_gen_o   (grp_gen_o)
);

// File: tb/lookahead_group4_tb.sv
`timescale 1ns/1ps
module lookahead_group4_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Device under test
    logic [3:0] prop, gen;
    logic       cin;
    logic [2:0] cmid;
    logic       cout, gp, gg;

    lookahead_group4 u_dut (
        .prop_i(prop), .gen_i(gen), .carry_i(cin),
        .carry_mid_o(cmid), .carry_out_o(cout),
        .grp_prop_o(gp), .grp_gen_o(gg)
    );

    // Two-tier 16-bit structure for R9
    logic [15:0] wa, wb, wp, wg;
    logic        wcin;
    logic [3:0]  lo_p, lo_g, seed;
    logic [2:0]  lo_mid [4];
    logic [2:0]  hi_mid;
    logic        lo_out [4];
    logic        hi_out, hi_gp, hi_gg;

    for (genvar q = 0; q < 4; q++) begin : g_lo
        lookahead_group4 u_lo (
            .prop_i(wp[4*q +: 4]), .gen_i(wg[4*q +: 4]), .carry_i(seed[q]),
            .carry_mid_o(lo_mid[q]), .carry_out_o(lo_out[q]),
            .grp_prop_o(lo_p[q]), .grp_gen_o(lo_g[q])
        );
    end
    lookahead_group4 u_hi (
        .prop_i(lo_p), .gen_i(lo_g), .carry_i(wcin),
        .carry_mid_o(hi_mid), .carry_out_o(hi_out),
        .grp_prop_o(hi_gp), .grp_gen_o(hi_gg)
    );
    assign seed = {hi_mid, wcin};

    // Count cycles; expired watchdog is a failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All zero inputs give all zero outputs
    task automatic t_reset_state();
        @(negedge clk);
        prop = '0; gen = '0; cin = 1'b0;
        #1;
        check({cmid, cout, gp, gg} == 6'b0, "R1 zero inputs", int'({cmid, cout, gp, gg}), 0);
    endtask

    // Sweep every operand pair and carry-in under one propagate form (R8)
    task automatic t_sweep(input bit use_xor);
        for (int v = 0; v < 512; v++) begin
            logic [3:0] a, b, pp, gv;
            logic       ci;
            logic [4:0] c;
            a = v[3:0]; b = v[7:4]; ci = v[8];
            pp = use_xor ? (a ^ b) : (a | b);
            gv = a & b;
            // Reference carries by bit-serial majority of operands
            c[0] = ci;
            for (int i = 0; i < 4; i++)
                c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
            @(negedge clk);
            prop = pp; gen = gv; cin = ci;
            #1;
            check(cmid[0] == c[1], "R1/R8 c1", cmid[0], c[1]);
            check(cmid[1] == c[2], "R2/R8 c2", cmid[1], c[2]);
            check(cmid[2] == c[3], "R3/R8 c3", cmid[2], c[3]);
            check(cout == c[4], "R4/R8 c4", cout, c[4]);
            check(gp == (&pp), "R5 group propagate", gp, &pp);
            check(gg == (a + b > 15), "R6 group generate", gg, int'(a + b > 15));
            check(cout == (gg | (gp & ci)), "R7 split", cout, gg | (gp & ci));
        end
    endtask

    // Group terms unchanged when only carry-in toggles (R5, R6)
    task automatic t_cin_independence();
        for (int v = 0; v < 256; v++) begin
            logic gp0, gg0;
            @(negedge clk);
            prop = v[3:0] | v[7:4]; gen = v[3:0] & v[7:4]; cin = 1'b0;
            #1;
            gp0 = gp; gg0 = gg;
            cin = 1'b1;
            #1;
            check(gp == gp0, "R5 P independent of carry-in", gp, gp0);
            check(gg == gg0, "R6 G independent of carry-in", gg, gg0);
        end
    endtask

    // Two-tier 16-bit addition (R9)
    task automatic t_two_tier(input bit use_xor);
        logic [31:0] lfsr = 32'hACE1_1234;
        for (int n = 0; n < 600; n++) begin
            logic [15:0] c16, s;
            logic [16:0] ref_sum;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            @(negedge clk);
            case (n)
                0: begin wa = 16'hFFFF; wb = 16'h0000; wcin = 1'b1; end
                1: begin wa = 16'hFFFF; wb = 16'hFFFF; wcin = 1'b1; end
                2: begin wa = 16'h0000; wb = 16'h0000; wcin = 1'b0; end
                default: begin wa = lfsr[15:0]; wb = lfsr[31:16] ^ 16'(n); wcin = lfsr[7]; end
            endcase
            wp = use_xor ? (wa ^ wb) : (wa | wb);
            wg = wa & wb;
            #1;
            for (int q = 0; q < 4; q++) c16[4*q +: 4] = {lo_mid[q], seed[q]};
            s = wa ^ wb ^ c16;
            ref_sum = 17'(wa) + 17'(wb) + 17'(wcin);
            check({hi_out, s} == ref_sum, "R9 two-tier sum", int'({hi_out, s}), int'(ref_sum));
            check(lo_out[3] == hi_out, "R9 top carry agreement", lo_out[3], hi_out);
        end
    endtask

    initial begin
        prop = '0; gen = '0; cin = 1'b0;
        wa = '0; wb = '0; wp = '0; wg = '0; wcin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_sweep(1'b0);
        t_sweep(1'b1);
        t_cin_independence();
        t_two_tier(1'b0);
        t_two_tier(1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule